// File: doc/BRIEF.md
# Iterative Rotate Execution Unit

This unit executes the register forms of the rotate-left and rotate-right instructions of a byte-coded instruction set. It takes the first opcode byte and the operand-selector byte, works out the direction, the operand width and where the rotate count comes from, and then rotates the latched operand by one bit position per clock. A private down-counter, loaded from a constant 1, from the CL register value or from an 8-bit immediate, sets how many steps run. The unit updates the carry flag on every step. It updates the overflow flag only when the count is the constant 1.

The surrounding execution stage pulses `start` with the instruction bytes and operands valid, then waits for the one-cycle `done` pulse. At that point `result`, the two flags, the decoded instruction length and an acceptance flag are stable. They hold until the next accepted start. Memory operands, address calculation and the other arithmetic flags are handled elsewhere.

Top module: `rot_iter_unit`

## Requirements
- R1: An instruction is accepted only when op_byte[7:1] is 7'b1101000 (count 1), 7'b1101001 (count from CL) or 7'b1100000 (count from immediate), modrm_byte[7:6] is 2'b11 and modrm_byte[5:3] is 3'b000 (left) or 3'b001 (right). op_ok reports this. A rejected start finishes like a zero count.
- R2: op_byte[0] = 0 rotates only result[7:0] and passes operand_in[15:8] through to result[15:8]. op_byte[0] = 1 rotates all 16 bits. The flag rules use bit 7 or bit 15 as the MSB to match.
- R3: Each left step moves the MSB into the carry flag, shifts the operand up by one, and places the new carry in bit 0.
- R4: Each right step moves bit 0 into the carry flag, shifts the operand down by one, and places the new carry in the MSB.
- R5: An accepted start performs exactly N steps, where N is 1, cl_in or imm_in according to the form. done is high in the cycle after N+1 rising edges, counting the edge that samples start.
- R6: When N is 0, or the start is rejected, result equals the operand, the carry and overflow flags keep their previous values, and done follows one edge after start.
- R7: For a left rotate by 1, ovf_flag becomes the new MSB XOR the new carry.
- R8: For a right rotate by 1, ovf_flag becomes the new MSB XOR the bit just below it.
- R9: The CL and immediate forms leave ovf_flag at its previous value.
- R10: instr_len reports 2 for the count-1 and CL forms, 3 for the immediate form, and 0 for a rejected start.
- R11: start is ignored in any cycle where the unit is busy or done is high.
- R12: done is a single-cycle pulse. result, the flags, instr_len and op_ok hold from done until the next accepted start. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an instruction when idle |
| op_byte | input | 8 | First opcode byte |
| modrm_byte | input | 8 | Operand-selector byte |
| operand_in | input | 16 | Register operand |
| cl_in | input | 8 | CL count value |
| imm_in | input | 8 | Immediate count value |
| result | output | 16 | Rotated operand |
| carry_flag | output | 1 | Carry flag |
| ovf_flag | output | 1 | Overflow flag |
| done | output | 1 | Completion pulse |
| instr_len | output | 2 | Decoded instruction length in bytes |
| op_ok | output | 1 | Instruction accepted |

## Verification
Two things can meet in one cycle: a new start request, and a running rotation or its completion pulse. The bench provokes this by raising start, with different operands, in the first busy cycle and again in the cycle where done is high. It judges the outcome by requiring that the step count, result and flags match the first instruction alone, and that no second done pulse follows the one carried by the ignored start.

// File: rtl/rot_pkg.sv
package rot_pkg;
  typedef enum logic [1:0] {
    SRC_ONE  = 2'd0,
    SRC_CL   = 2'd1,
    SRC_IMM  = 2'd2,
    SRC_NONE = 2'd3
  } cnt_src_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } ctl_state_e;

  typedef struct packed {
    logic     ok;
    logic     dir_right;
    logic     wide;
    cnt_src_e src;
    logic [1:0] len;
  } rot_dec_t;

  localparam logic [6:0] OPC_BY_ONE = 7'b1101000;
  localparam logic [6:0] OPC_BY_CL  = 7'b1101001;
  localparam logic [6:0] OPC_BY_IMM = 7'b1100000;
endpackage

// File: rtl/rot_rst_sync.sv
module rot_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rot_decode.sv
module rot_decode
  import rot_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [7:0]       op_byte,
  input  logic [7:0]       modrm_byte,
  input  logic [CNT_W-1:0] cl_in,
  input  logic [CNT_W-1:0] imm_in,
  output rot_dec_t         dec,
  output logic [CNT_W-1:0] count
);
  logic reg_form;
  logic rot_sel;
  logic unused_rm;

  assign unused_rm = ^modrm_byte[2:0];
  assign reg_form  = (modrm_byte[7:6] == 2'b11);
  assign rot_sel   = (modrm_byte[5:4] == 2'b00);

  always_comb begin
    dec.src = SRC_NONE;
    if (op_byte[7:1] == OPC_BY_ONE)      dec.src = SRC_ONE;
    else if (op_byte[7:1] == OPC_BY_CL)  dec.src = SRC_CL;
    else if (op_byte[7:1] == OPC_BY_IMM) dec.src = SRC_IMM;

    dec.ok        = reg_form && rot_sel && (dec.src != SRC_NONE);
    dec.dir_right = modrm_byte[3];
    dec.wide      = op_byte[0];

    dec.len = 2'd0;
    if (dec.ok) dec.len = (dec.src == SRC_IMM) ? 2'd3 : 2'd2;

    unique case (dec.src)
      SRC_ONE: count = {{(CNT_W-1){1'b0}}, 1'b1};
      SRC_CL:  count = cl_in;
      SRC_IMM: count = imm_in;
      default: count = '0;
    endcase
    if (!dec.ok) count = '0;
  end
endmodule

// File: rtl/rot_step.sv
module rot_step #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] val_in,
  input  logic              wide,
  input  logic              dir_right,
  output logic [DATA_W-1:0] val_out,
  output logic              cf_out,
  output logic              of_out
);
  localparam int HALF = DATA_W / 2;

  logic [DATA_W-1:0] rot_full;
  logic [HALF-1:0]   rot_half;
  logic              cf_full;
  logic              cf_half;

  always_comb begin
    if (dir_right) begin
      cf_full  = val_in[0];
      rot_full = {val_in[0], val_in[DATA_W-1:1]};
      cf_half  = val_in[0];
      rot_half = {val_in[0], val_in[HALF-1:1]};
    end else begin
      cf_full  = val_in[DATA_W-1];
      rot_full = {val_in[DATA_W-2:0], val_in[DATA_W-1]};
      cf_half  = val_in[HALF-1];
      rot_half = {val_in[HALF-2:0], val_in[HALF-1]};
    end
  end

  always_comb begin
    if (wide) begin
      val_out = rot_full;
      cf_out  = cf_full;
      of_out  = dir_right ? (rot_full[DATA_W-1] ^ rot_full[DATA_W-2])
                          : (rot_full[DATA_W-1] ^ cf_full);
    end else begin
      val_out = {val_in[DATA_W-1:HALF], rot_half};
      cf_out  = cf_half;
      of_out  = dir_right ? (rot_half[HALF-1] ^ rot_half[HALF-2])
                          : (rot_half[HALF-1] ^ cf_half);
    end
  end
endmodule

// File: rtl/rot_ctrl.sv
module rot_ctrl
  import rot_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] cnt_load,
  output logic             load,
  output logic             step,
  output logic             idle,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  ctl_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign idle = (state_q == ST_IDLE);
  assign load = idle && start;
  assign step = (state_q == ST_RUN);
  assign done = (state_q == ST_FIN);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = (cnt_load == '0) ? ST_FIN : ST_RUN;
      ST_RUN:  if (cnt_q == CNT_ONE) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    cnt_en = load || step;
    cnt_d  = load ? cnt_load : (cnt_q - CNT_ONE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/rot_iter_unit.sv
module rot_iter_unit
  import rot_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CNT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [7:0]        op_byte,
  input  logic [7:0]        modrm_byte,
  input  logic [DATA_W-1:0] operand_in,
  input  logic [CNT_W-1:0]  cl_in,
  input  logic [CNT_W-1:0]  imm_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_flag,
  output logic              ovf_flag,
  output logic              done,
  output logic [1:0]        instr_len,
  output logic              op_ok
);
  logic             rst_sync_n;
  rot_dec_t         dec;
  logic [CNT_W-1:0] dec_cnt;
  logic             ctl_load, ctl_step, ctl_idle, ctl_done;

  logic [DATA_W-1:0] work_q, work_d;
  logic              cf_q, cf_d, of_q, of_d;
  logic              wide_q, dir_q, single_q;
  logic [1:0]        len_q;
  logic              ok_q;
  logic [DATA_W-1:0] step_val;
  logic              step_cf, step_of;
  logic              work_en, cf_en, of_en;

  rot_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rot_decode #(.CNT_W(CNT_W)) u_dec (
    .op_byte    (op_byte),
    .modrm_byte (modrm_byte),
    .cl_in      (cl_in),
    .imm_in     (imm_in),
    .dec        (dec),
    .count      (dec_cnt)
  );

  rot_ctrl #(.CNT_W(CNT_W)) u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .cnt_load (dec_cnt),
    .load     (ctl_load),
    .step     (ctl_step),
    .idle     (ctl_idle),
    .done     (ctl_done)
  );

  rot_step #(.DATA_W(DATA_W)) u_step (
    .val_in    (work_q),
    .wide      (wide_q),
    .dir_right (dir_q),
    .val_out   (step_val),
    .cf_out    (step_cf),
    .of_out    (step_of)
  );

  always_comb begin
    work_en = ctl_load || ctl_step;
    work_d  = ctl_load ? operand_in : step_val;
    cf_en   = ctl_step;
    cf_d    = step_cf;
    of_en   = ctl_step && single_q;
    of_d    = step_of;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  work_q <= '0;
    else if (work_en) work_q <= work_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) cf_q <= 1'b0;
    else if (cf_en)  cf_q <= cf_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) of_q <= 1'b0;
    else if (of_en)  of_q <= of_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      wide_q   <= 1'b0;
      dir_q    <= 1'b0;
      single_q <= 1'b0;
      len_q    <= 2'd0;
      ok_q     <= 1'b0;
    end else if (ctl_load) begin
      wide_q   <= dec.wide;
      dir_q    <= dec.dir_right;
      single_q <= (dec.src == SRC_ONE);
      len_q    <= dec.len;
      ok_q     <= dec.ok;
    end
  end

  assign result     = work_q;
  assign carry_flag = cf_q;
  assign ovf_flag   = of_q;
  assign done       = ctl_done;
  assign instr_len  = len_q;
  assign op_ok      = ok_q;
endmodule

// File: rtl/rot_iter_chk.sv
module rot_iter_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              idle,
  input logic              step,
  input logic              single,
  input logic              done,
  input logic [DATA_W-1:0] result,
  input logic              carry_flag,
  input logic              ovf_flag
);
  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  carry_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(carry_flag));

  // R9
  ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(step && single) |=> $stable(ovf_flag));

  // R11
  busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !step) |=> $stable(result));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !start) |=> $stable(result));

  // R5
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> idle);
endmodule

bind rot_iter_unit rot_iter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .start      (start),
  .idle       (ctl_idle),
  .step       (ctl_step),
  .single     (single_q),
  .done       (done),
  .result     (result),
  .carry_flag (carry_flag),
  .ovf_flag   (ovf_flag)
);

// File: tb/test_rot_iter_unit.sv
module test_rot_iter_unit;
  logic        clk;
  logic        rst_n;
  logic        start;
  logic [7:0]  op_byte, modrm_byte, cl_in, imm_in;
  logic [15:0] operand_in;
  logic [15:0] result;
  logic        carry_flag, ovf_flag, done, op_ok;
  logic [1:0]  instr_len;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic exp_cf = 1'b0;
  logic exp_of = 1'b0;

  typedef struct packed {
    logic [15:0] res;
    logic        cf;
    logic        of;
    logic [1:0]  len;
    logic        ok;
    logic [8:0]  steps;
  } exp_t;

  rot_iter_unit i_rot_iter_unit (
    .clk, .rst_n, .start, .op_byte, .modrm_byte, .operand_in, .cl_in, .imm_in,
    .result, .carry_flag, .ovf_flag, .done, .instr_len, .op_ok
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      finish_run();
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  function automatic exp_t model(input logic [7:0] op, input logic [7:0] rm,
                                 input logic [15:0] v_in, input logic [7:0] cl,
                                 input logic [7:0] imm, input logic cf_in, input logic of_in);
    exp_t e;
    logic [15:0] v;
    logic c, o, msb, w, one;
    int n;
    w = op[0];
    e.ok = (rm[7:6] == 2'b11) && (rm[5:4] == 2'b00) &&
           (op[7:1] == 7'h68 || op[7:1] == 7'h69 || op[7:1] == 7'h60);
    one = (op[7:1] == 7'h68);
    n = !e.ok ? 0 : one ? 1 : (op[7:1] == 7'h69) ? int'(cl) : int'(imm);
    e.len = !e.ok ? 2'd0 : (op[7:1] == 7'h60) ? 2'd3 : 2'd2;
    v = v_in; c = cf_in; o = of_in;
    for (int i = 0; i < n; i++) begin
      if (!rm[3]) begin
        c = w ? v[15] : v[7];
        if (w) v = (v << 1) | {15'd0, c};
        else   v = {v[15:8], v[6:0], c};
      end else begin
        c = v[0];
        if (w) v = (v >> 1) | {c, 15'd0};
        else   v = {v[15:8], c, v[7:1]};
      end
    end
    if (one && e.ok) begin
      msb = w ? v[15] : v[7];
      o = rm[3] ? (msb ^ (w ? v[14] : v[6])) : (msb ^ c);
    end
    e.res = v; e.cf = c; e.of = o; e.steps = 9'(n);
    return e;
  endfunction

  task automatic run_op(input logic [7:0] op, input logic [7:0] rm, input logic [15:0] v,
                        input logic [7:0] cl, input logic [7:0] imm,
                        input bit poke_busy, input bit poke_done);
    exp_t e;
    int edges;
    e = model(op, rm, v, cl, imm, exp_cf, exp_of);
    @(negedge clk);
    op_byte = op; modrm_byte = rm; operand_in = v; cl_in = cl; imm_in = imm; start = 1'b1;
    @(negedge clk);
    edges = 1;
    start = 1'b0;
    while (!done && edges < 400) begin
      if (poke_busy && edges == 1) begin
        // R11: start while busy must be dropped
        start = 1'b1; operand_in = ~v; op_byte = 8'hD0; modrm_byte = 8'hC0;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      edges++;
    end
    start = 1'b0;
    check("R5 step timing", edges, int'(e.steps) + 1);
    check("R3/R4 result", result, e.res);
    check("R3/R4 carry", carry_flag, e.cf);
    check("R7/R8/R9 overflow", ovf_flag, e.of);
    check("R10 length", instr_len, e.len);
    check("R1 accept", op_ok, e.ok);
    if (poke_done) begin
      // R11: start during the done cycle is dropped
      start = 1'b1; operand_in = ~v; op_byte = 8'hD0; modrm_byte = 8'hC0;
      @(negedge clk);
      start = 1'b0;
      check("R12 done single pulse", done, 1'b0);
      @(negedge clk);
      check("R11 no extra done", done, 1'b0);
      check("R11 result held", result, e.res);
    end
    exp_cf = e.cf;
    exp_of = e.of;
  endtask

  initial begin
    logic [7:0] op, rm, cnt;
    void'($urandom(32'd4711));
    rst_n = 1'b0; start = 1'b0;
    op_byte = 8'h0; modrm_byte = 8'h0; operand_in = 16'h0; cl_in = 8'h0; imm_in = 8'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R12 reset result", result, 16'h0);
    check("R12 reset carry", carry_flag, 1'b0);
    check("R12 reset ovf", ovf_flag, 1'b0);
    check("R12 reset done", done, 1'b0);
    check("R12 reset len", instr_len, 2'd0);
    check("R12 reset ok", op_ok, 1'b0);

    // R7 byte left by 1: 0x80 -> 0x01, cf=1, of=1; upper byte passes (R2)
    run_op(8'hD0, 8'hC0, 16'hAB80, 8'h0, 8'h0, 1'b0, 1'b1);
    // R8 byte right by 1: 0x01 -> 0x80, cf=1, of=1
    run_op(8'hD0, 8'hC8, 16'h0001, 8'h0, 8'h0, 1'b0, 1'b0);
    // R7 word left by 1: 0x4000 -> 0x8000, cf=0, of=1
    run_op(8'hD1, 8'hC1, 16'h4000, 8'h0, 8'h0, 1'b0, 1'b0);
    // R6 zero counts from CL and from the immediate
    run_op(8'hD3, 8'hC2, 16'h1234, 8'h00, 8'h05, 1'b0, 1'b1);
    run_op(8'hC1, 8'hCB, 16'h5678, 8'h07, 8'h00, 1'b0, 1'b0);
    // R9 multi-step keeps ovf; R5 long immediate count
    run_op(8'hC1, 8'hC3, 16'h8001, 8'h00, 8'd255, 1'b1, 1'b0);
    // R1 rejected: memory form, bad reg field, bad opcode
    run_op(8'hD2, 8'h03, 16'hBEEF, 8'h03, 8'h0, 1'b0, 1'b1);
    run_op(8'hD1, 8'hD0, 16'hBEEF, 8'h0, 8'h0, 1'b0, 1'b0);
    run_op(8'hD4, 8'hC0, 16'hBEEF, 8'h0, 8'h0, 1'b0, 1'b0);

    for (int k = 0; k < 250; k++) begin
      case ($urandom % 4)
        0: op = 8'hD0;
        1: op = 8'hD2;
        2: op = 8'hC0;
        default: op = 8'hD0 | 8'($urandom % 16);
      endcase
      op[0] = 1'($urandom);
      rm = {2'b11, 3'b000, 3'($urandom)};
      rm[3] = 1'($urandom);
      if ($urandom % 10 == 0) rm = 8'($urandom);
      cnt = ($urandom % 8 == 0) ? 8'($urandom) : 8'($urandom % 20);
      run_op(op, rm, 16'($urandom), cnt, 8'($urandom % 24),
             ($urandom % 3) == 0, ($urandom % 3) == 0);
    end

    finish_run();
  end
endmodule